// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload Timer

This block is a 16-bit timer/counter of the classic 8-bit microcontroller kind. One counter serves four behaviours picked from a small set of control bits: plain auto-reload, capture of the running count on an external pin edge, up/down counting with the direction taken from a pin, and a free-running reload mode that produces a baud-rate tick for a neighbouring serial port. The counter advances either once per machine cycle or on each falling transition seen on an external count pin. A clock-out output can toggle on every reload.

Software reaches the block through a byte-wide register port. A write takes effect on the clock edge where `wr_en` is high. A read is combinational from `addr`. The two pin inputs are asynchronous and are synchronized inside the block. The interrupt request is level-high while a pending flag that requests service is set.

Top module: `t2_timer`

## Requirements
- R1: After reset every register reads 0, and `irq`, `baud_tick` and `clk_out` are 0.
- R2: With the timer/counter select bit (control bit 1) at 0 and run (control bit 2) at 1, the count goes up by one every 12 clocks when `cyc_fast`=0 and every 6 clocks when `cyc_fast`=1.
- R3: With control bit 1 at 1, the count goes up once for each falling transition of `t2_pin`. A transition is recognised as a 1 followed by a 0 on two consecutive machine-cycle samples of the synchronized pin.
- R4: With run at 0, neither machine cycles nor pin edges change the count.
- R5: In auto-reload mode (bits 5, 4 and 0 at 0, down-count enable at 0), a count event at 0xFFFF loads the reload value and sets the overflow flag (control bit 7).
- R6: In auto-reload mode with the external enable (control bit 3) at 1, a falling transition on `t2ex_pin` loads the reload value and sets the external flag (control bit 6).
- R7: In capture mode (control bit 0 at 1), a falling transition on `t2ex_pin` with bit 3 at 1 copies the count into the reload/capture register and sets bit 6. An overflow wraps the count to 0 and sets bit 7.
- R8: In auto-reload mode with down-count enable (mode register bit 0) at 1, the count goes up while `t2ex_pin` is 1, reloading from the reload value after 0xFFFF. It goes down while `t2ex_pin` is 0, and a count event at the reload value loads 0xFFFF. Both wraps set bit 7 and toggle bit 6, and bit 6 then raises no interrupt.
- R9: When bit 5 or bit 4 is 1, the block is a baud generator, and this takes priority over bit 0. Each overflow loads the reload value and gives a one-clock `baud_tick` pulse in the cycle after the load. Bit 7 stays 0.
- R10: With clock-out enable (mode register bit 1) at 1 and control bit 1 at 0, `clk_out` toggles on every overflow in auto-reload or baud mode. With control bit 1 at 1 it does not toggle.
- R11: Bits 7 and 6 are set only by hardware. A control write clears a flag where the written bit is 0 and leaves it unchanged where it is 1. `irq` is the OR of bit 7 and bit 6, except that bit 6 is left out in up/down mode.
- R12: The register map is: 0xC8 control, 0xC9 mode, 0xCA/0xCB reload low/high, 0xCC/0xCD count low/high. Mode register bits 7..2 read 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_fast | input | 1 | 1: machine cycle of 6 clocks, 0: 12 clocks |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| t2_pin | input | 1 | External count pin (asynchronous) |
| t2ex_pin | input | 1 | Capture/reload trigger and direction pin (asynchronous) |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse per baud-mode overflow |
| clk_out | output | 1 | Clock-out toggle output |

## Verification
The bench aims at the wrap points. It runs from 0xFFFE through the overflow in each mode and, in up/down mode, down through the reload value. A design with the wrong wrap target would show 0x0000 where the reload value belongs, or the reverse. It also drives the baud mode with the capture bit set. A design that got the mode priority wrong would then set the overflow flag and emit no tick. The bench writes 1s and 0s into the flags and checks that the interrupt stays low in up/down mode, which catches flags that software can set or an interrupt that is wrongly unmasked. The machine-cycle divide is measured as an exact count difference over a fixed window in both speeds, and clock-out toggles are counted over a window of exactly ten reloads.

// File: rtl/t2_pkg.sv
package t2_pkg;

  localparam logic [7:0] ADDR_CTL  = 8'hC8;
  localparam logic [7:0] ADDR_MOD  = 8'hC9;
  localparam logic [7:0] ADDR_CAPL = 8'hCA;
  localparam logic [7:0] ADDR_CAPH = 8'hCB;
  localparam logic [7:0] ADDR_CNTL = 8'hCC;
  localparam logic [7:0] ADDR_CNTH = 8'hCD;

  // control register bit positions
  localparam int B_OVF   = 7;
  localparam int B_EXT   = 6;
  localparam int B_RXB   = 5;
  localparam int B_TXB   = 4;
  localparam int B_EXEN  = 3;
  localparam int B_RUN   = 2;
  localparam int B_SRC   = 1;
  localparam int B_CAPT  = 0;

  // mode register bit positions
  localparam int B_OE    = 1;
  localparam int B_DOWN  = 0;

  typedef enum logic [1:0] {
    T2M_RELOAD  = 2'd0,
    T2M_CAPTURE = 2'd1,
    T2M_BAUD    = 2'd2,
    T2M_UPDOWN  = 2'd3
  } t2_mode_e;

endpackage

// File: rtl/t2_cycle_gen.sv
module t2_cycle_gen #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6
) (
  input  logic clk,
  input  logic rst_s,
  input  logic fast,
  output logic tick
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] LIM_S = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] LIM_F = CW'(DIV_FAST - 1);

  logic [CW-1:0] div_q, div_n;
  logic [CW-1:0] lim;

  always_comb begin
    lim  = fast ? LIM_F : LIM_S;
    tick = (div_q >= lim);
    div_n = tick ? '0 : div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/t2_pin_sync.sv
module t2_pin_sync (
  input  logic clk,
  input  logic rst_s,
  input  logic pin,
  input  logic tick,
  output logic cur,
  output logic prev
);
  logic s1_q, s2_q, smp_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      smp_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      if (tick) smp_q <= s2_q;
    end
  end

  assign cur  = s2_q;
  assign prev = smp_q;
endmodule

// File: rtl/t2_count_core.sv
module t2_count_core
  import t2_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_s,
  input  t2_mode_e          mode,
  input  logic              run,
  input  logic              cnt_en,
  input  logic              ext_evt,
  input  logic              dir_up,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_cap_lo,
  input  logic              wr_cap_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              ovf,
  output logic              unf
);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_MAX = '1;

  logic [CNT_W-1:0] cnt_n, cap_n;
  logic at_max;

  always_comb begin
    cnt_n  = cnt_q;
    cap_n  = cap_q;
    ovf    = 1'b0;
    unf    = 1'b0;
    at_max = (cnt_q == C_MAX);

    if (run && cnt_en) begin
      unique case (mode)
        T2M_UPDOWN: begin
          if (dir_up) begin
            if (at_max) begin cnt_n = cap_q; ovf = 1'b1; end
            else              cnt_n = cnt_q + C_ONE;
          end else begin
            if (cnt_q == cap_q) begin cnt_n = C_MAX; unf = 1'b1; end
            else                      cnt_n = cnt_q - C_ONE;
          end
        end
        T2M_CAPTURE: begin
          cnt_n = cnt_q + C_ONE;
          ovf   = at_max;
        end
        default: begin
          if (at_max) begin cnt_n = cap_q; ovf = 1'b1; end
          else              cnt_n = cnt_q + C_ONE;
        end
      endcase
    end

    if (ext_evt) begin
      if (mode == T2M_RELOAD)  cnt_n = cap_q;
      if (mode == T2M_CAPTURE) cap_n = cnt_q;
    end

    if (wr_lo)     cnt_n[BYTE_W-1:0]     = wdata;
    if (wr_hi)     cnt_n[CNT_W-1:BYTE_W] = wdata;
    if (wr_cap_lo) cap_n[BYTE_W-1:0]     = wdata;
    if (wr_cap_hi) cap_n[CNT_W-1:BYTE_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      cap_q <= cap_n;
    end
  end
endmodule

// File: rtl/t2_timer.sv
module t2_timer
  import t2_pkg::*;
#(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_fast,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              t2_pin,
  input  logic              t2ex_pin,
  output logic              irq,
  output logic              baud_tick,
  output logic              clk_out
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam int NPIN  = 2;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_s <= rs1_q;
    end
  end

  // machine-cycle tick
  logic tick;
  t2_cycle_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_cyc (
    .clk(clk), .rst_s(rst_s), .fast(cyc_fast), .tick(tick)
  );

  // pin synchronizers and edge detection: index 0 = count pin, 1 = trigger pin
  logic [NPIN-1:0] pin_in, pin_cur, pin_prev, pin_fall;
  assign pin_in = {t2ex_pin, t2_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    t2_pin_sync u_sync (
      .clk(clk), .rst_s(rst_s), .pin(pin_in[g]), .tick(tick),
      .cur(pin_cur[g]), .prev(pin_prev[g])
    );
    assign pin_fall[g] = tick & pin_prev[g] & ~pin_cur[g];
  end

  // control state
  logic tf2_q, exf2_q, rxb_q, txb_q, exen2_q, tr2_q, ct2_q, capt_q;
  logic t2oe_q, dcen_q, clk_out_q, baud_q;
  logic tf2_n, exf2_n, clk_out_n, baud_n;

  logic wr_ctl, wr_mod, wr_capl, wr_caph, wr_cntl, wr_cnth;
  always_comb begin
    wr_ctl  = wr_en && (addr == ADDR_W'(ADDR_CTL));
    wr_mod  = wr_en && (addr == ADDR_W'(ADDR_MOD));
    wr_capl = wr_en && (addr == ADDR_W'(ADDR_CAPL));
    wr_caph = wr_en && (addr == ADDR_W'(ADDR_CAPH));
    wr_cntl = wr_en && (addr == ADDR_W'(ADDR_CNTL));
    wr_cnth = wr_en && (addr == ADDR_W'(ADDR_CNTH));
  end

  // mode decode: baud has priority, then capture, then up/down, then reload
  t2_mode_e mode;
  logic     mode_baud;
  always_comb begin
    if (rxb_q || txb_q) mode = T2M_BAUD;
    else if (capt_q)    mode = T2M_CAPTURE;
    else if (dcen_q)    mode = T2M_UPDOWN;
    else                mode = T2M_RELOAD;
    mode_baud = (mode == T2M_BAUD);
  end

  logic cnt_en, ext_evt, ovf, unf;
  logic [CNT_W-1:0] cnt_val, cap_val;
  assign cnt_en  = ct2_q ? pin_fall[0] : tick;
  assign ext_evt = exen2_q & pin_fall[1];

  t2_count_core #(.BYTE_W(BYTE_W)) u_core (
    .clk(clk), .rst_s(rst_s), .mode(mode), .run(tr2_q),
    .cnt_en(cnt_en), .ext_evt(ext_evt), .dir_up(pin_cur[1]),
    .wr_lo(wr_cntl), .wr_hi(wr_cnth), .wr_cap_lo(wr_capl), .wr_cap_hi(wr_caph),
    .wdata(wdata), .cnt_q(cnt_val), .cap_q(cap_val), .ovf(ovf), .unf(unf)
  );

  // flag and output next state
  always_comb begin
    tf2_n  = wr_ctl ? (tf2_q  & wdata[B_OVF]) : tf2_q;
    exf2_n = wr_ctl ? (exf2_q & wdata[B_EXT]) : exf2_q;
    if ((ovf && !mode_baud) || unf) tf2_n = 1'b1;
    if (mode == T2M_UPDOWN) begin
      if (ovf || unf) exf2_n = ~exf2_n;
    end else if (ext_evt) begin
      exf2_n = 1'b1;
    end
    clk_out_n = clk_out_q;
    if (t2oe_q && !ct2_q && ovf && (mode == T2M_RELOAD || mode_baud))
      clk_out_n = ~clk_out_q;
    baud_n = ovf && mode_baud;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      tf2_q     <= 1'b0;
      exf2_q    <= 1'b0;
      rxb_q     <= 1'b0;
      txb_q     <= 1'b0;
      exen2_q   <= 1'b0;
      tr2_q     <= 1'b0;
      ct2_q     <= 1'b0;
      capt_q    <= 1'b0;
      t2oe_q    <= 1'b0;
      dcen_q    <= 1'b0;
      clk_out_q <= 1'b0;
      baud_q    <= 1'b0;
    end else begin
      tf2_q     <= tf2_n;
      exf2_q    <= exf2_n;
      clk_out_q <= clk_out_n;
      baud_q    <= baud_n;
      if (wr_ctl) begin
        rxb_q   <= wdata[B_RXB];
        txb_q   <= wdata[B_TXB];
        exen2_q <= wdata[B_EXEN];
        tr2_q   <= wdata[B_RUN];
        ct2_q   <= wdata[B_SRC];
        capt_q  <= wdata[B_CAPT];
      end
      if (wr_mod) begin
        t2oe_q <= wdata[B_OE];
        dcen_q <= wdata[B_DOWN];
      end
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_CTL)) begin
      rdata[B_OVF]  = tf2_q;
      rdata[B_EXT]  = exf2_q;
      rdata[B_RXB]  = rxb_q;
      rdata[B_TXB]  = txb_q;
      rdata[B_EXEN] = exen2_q;
      rdata[B_RUN]  = tr2_q;
      rdata[B_SRC]  = ct2_q;
      rdata[B_CAPT] = capt_q;
    end else if (addr == ADDR_W'(ADDR_MOD)) begin
      rdata[B_OE]   = t2oe_q;
      rdata[B_DOWN] = dcen_q;
    end else if (addr == ADDR_W'(ADDR_CAPL)) rdata = cap_val[BYTE_W-1:0];
    else if (addr == ADDR_W'(ADDR_CAPH))     rdata = cap_val[CNT_W-1:BYTE_W];
    else if (addr == ADDR_W'(ADDR_CNTL))     rdata = cnt_val[BYTE_W-1:0];
    else if (addr == ADDR_W'(ADDR_CNTH))     rdata = cnt_val[CNT_W-1:BYTE_W];
  end

  assign irq       = tf2_q | (exf2_q & (mode != T2M_UPDOWN));
  assign baud_tick = baud_q;
  assign clk_out   = clk_out_q;
endmodule

// File: rtl/t2_timer_chk.sv
module t2_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             wr_en,
  input logic             tf2_q,
  input logic             tr2_q,
  input logic             exen2_q,
  input logic             ct2_q,
  input logic             t2oe_q,
  input logic             mode_baud,
  input logic [CNT_W-1:0] cnt_val,
  input logic             baud_tick,
  input logic             clk_out
);
  // flag only falls through a register write
  assert_flag_sw_clear_R11: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(tf2_q) |-> $past(wr_en));

  // stopped counter with no trigger enable and no write keeps its value
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (!tr2_q && !exen2_q && !wr_en) |=> $stable(cnt_val));

  // overflow flag never rises out of baud mode
  assert_no_flag_in_baud_R9: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(tf2_q) |-> !$past(mode_baud));

  // tick only follows a baud-mode cycle
  assert_tick_from_baud_R9: assert property (@(posedge clk) disable iff (!rst_s)
    baud_tick |-> $past(mode_baud));

  // clock-out changes only when enabled in timer mode
  assert_clkout_source_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (clk_out != $past(clk_out)) |-> ($past(t2oe_q) && !$past(ct2_q)));
endmodule

bind t2_timer t2_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .wr_en(wr_en), .tf2_q(tf2_q), .tr2_q(tr2_q),
  .exen2_q(exen2_q), .ct2_q(ct2_q), .t2oe_q(t2oe_q), .mode_baud(mode_baud),
  .cnt_val(cnt_val), .baud_tick(baud_tick), .clk_out(clk_out)
);

// File: tb/tb_t2_timer.sv
`timescale 1ns/1ps
module tb_t2_timer;
  logic       clk, rst_n, cyc_fast, wr_en, t2_pin, t2ex_pin;
  logic [7:0] addr, wdata, rdata;
  logic       irq, baud_tick, clk_out;

  int n_tests = 0;
  int n_fail  = 0;
  int n_baud  = 0;
  int n_tog   = 0;
  logic co_prev = 1'b0;

  t2_timer dut (
    .clk(clk), .rst_n(rst_n), .cyc_fast(cyc_fast), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .t2_pin(t2_pin),
    .t2ex_pin(t2ex_pin), .irq(irq), .baud_tick(baud_tick), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (baud_tick) n_baud++;
    if (clk_out !== co_prev) n_tog++;
    co_prev = clk_out;
  end

  // expected-value functions
  function automatic logic [15:0] f_up(input logic [15:0] c, input logic [15:0] r);
    return (c == 16'hFFFF) ? r : c + 16'd1;
  endfunction
  function automatic logic [15:0] f_down(input logic [15:0] c, input logic [15:0] r);
    return (c == r) ? 16'hFFFF : c - 16'd1;
  endfunction
  function automatic logic [7:0] f_readback(input logic [7:0] a, input logic [7:0] d);
    return (a == 8'hC9) ? (d & 8'h03) : d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rd16(input logic [7:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l); rd(lo + 8'd1, h);
    v = {h, l};
  endtask

  task automatic set16(input logic [7:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]); wr(lo + 8'd1, v[15:8]);
  endtask

  task automatic pulse_t2(input int n);
    for (int i = 0; i < n; i++) begin
      t2_pin = 1'b1; repeat (20) @(negedge clk);
      t2_pin = 1'b0; repeat (20) @(negedge clk);
    end
  endtask

  task automatic pulse_ex();
    t2ex_pin = 1'b1; repeat (20) @(negedge clk);
    t2ex_pin = 1'b0; repeat (20) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0]  b, b2;
    logic [15:0] v, e;
    int t0;
    rst_n = 1'b0; cyc_fast = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
    t2_pin = 1'b0; t2ex_pin = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 8'hC8; a <= 8'hCD; a++) begin
      rd(8'(a), b); chk("R1 reset register", b, 8'h00);
    end
    chk("R1 reset irq", irq, 1'b0);
    chk("R1 reset baud_tick", baud_tick, 1'b0);
    chk("R1 reset clk_out", clk_out, 1'b0);

    // R12: random register readback with counter stopped
    void'($urandom(32'h5EED_0021));
    for (int i = 0; i < 40; i++) begin
      logic [7:0] a, d;
      a = 8'hC9 + 8'($urandom_range(0, 4));
      d = 8'($urandom);
      wr(a, d); rd(a, b);
      chk("R12 readback", b, f_readback(a, d));
    end
    rd(8'h00, b); chk("R12 unmapped reads 0", b, 8'h00);
    wr(8'hC9, 8'hFF); rd(8'hC9, b); chk("R12 reserved bits read 0", b, 8'h03);
    wr(8'hC9, 8'h00);

    // R2: machine-cycle divide in both speeds
    set16(8'hCC, 16'h0000);
    wr(8'hC8, 8'h04);
    repeat (30) @(negedge clk);
    rd(8'hCC, b); repeat (12 * 50) @(negedge clk); #1 b2 = rdata;
    chk("R2 12-clock cycle", 8'(b2 - b), 8'd50);
    cyc_fast = 1'b1; repeat (30) @(negedge clk);
    rd(8'hCC, b); repeat (6 * 50) @(negedge clk); #1 b2 = rdata;
    chk("R2 6-clock cycle", 8'(b2 - b), 8'd50);

    // R4: stopped counter ignores cycles and pin edges
    wr(8'hC8, 8'h00);
    rd16(8'hCC, v); repeat (300) @(negedge clk); rd16(8'hCC, e);
    chk("R4 stopped timer holds", e, v);
    wr(8'hC8, 8'h02); pulse_t2(3); rd16(8'hCC, e);
    chk("R4 stopped counter holds", e, v);

    // R3: counting pin edges
    set16(8'hCC, 16'h0000);
    wr(8'hC8, 8'h06); pulse_t2(5); rd16(8'hCC, v);
    chk("R3 five pin edges", v, 16'd5);

    // R5: auto-reload on overflow
    wr(8'hC8, 8'h02);
    set16(8'hCA, 16'h1234); set16(8'hCC, 16'hFFFE);
    wr(8'hC8, 8'h06);
    e = f_up(f_up(16'hFFFE, 16'h1234), 16'h1234);
    pulse_t2(2); rd16(8'hCC, v);
    chk("R5 reload value", v, e);
    rd(8'hC8, b); chk("R5 overflow flag", b, 8'h86);
    chk("R11 irq on overflow", irq, 1'b1);

    // R11: writing 1 keeps, writing 0 clears, 1 cannot set
    wr(8'hC8, 8'h86); rd(8'hC8, b); chk("R11 write 1 keeps flag", b, 8'h86);
    wr(8'hC8, 8'h06); rd(8'hC8, b); chk("R11 write 0 clears flag", b, 8'h06);
    chk("R11 irq cleared", irq, 1'b0);
    wr(8'hC8, 8'hC6); rd(8'hC8, b); chk("R11 write 1 does not set", b, 8'h06);

    // R6: external reload
    set16(8'hCC, 16'h0500);
    wr(8'hC8, 8'h0E); pulse_ex(); rd16(8'hCC, v);
    chk("R6 external reload", v, 16'h1234);
    rd(8'hC8, b); chk("R6 external flag", b, 8'h4E);
    chk("R11 irq on external flag", irq, 1'b1);
    wr(8'hC8, 8'h02);

    // R7: capture
    set16(8'hCA, 16'h0000); set16(8'hCC, 16'h0203);
    wr(8'hC8, 8'h0F); pulse_ex();
    rd16(8'hCA, v); chk("R7 captured value", v, 16'h0203);
    rd16(8'hCC, v); chk("R7 count untouched", v, 16'h0203);
    set16(8'hCC, 16'hFFFF); pulse_t2(1);
    rd16(8'hCC, v); chk("R7 wrap to zero", v, 16'h0000);
    rd(8'hC8, b); chk("R7 both flags", b, 8'hCF);
    wr(8'hC8, 8'h03);

    // R8: up/down counting
    wr(8'hC9, 8'h01);
    set16(8'hCA, 16'h0010); set16(8'hCC, 16'h0012);
    t2ex_pin = 1'b0;
    wr(8'hC8, 8'h06);
    e = f_down(f_down(16'h0012, 16'h0010), 16'h0010);
    pulse_t2(2); rd16(8'hCC, v); chk("R8 count down", v, e);
    pulse_t2(1); rd16(8'hCC, v); chk("R8 underflow to max", v, f_down(e, 16'h0010));
    rd(8'hC8, b); chk("R8 flags after underflow", b, 8'hC6);
    wr(8'hC8, 8'h46); rd(8'hC8, b); chk("R8 external flag kept", b, 8'h46);
    chk("R8 external flag masked from irq", irq, 1'b0);
    t2ex_pin = 1'b1; repeat (20) @(negedge clk);
    pulse_t2(1); rd16(8'hCC, v); chk("R8 count up reload", v, f_up(16'hFFFF, 16'h0010));
    rd(8'hC8, b); chk("R8 external flag toggles back", b, 8'h86);
    t2ex_pin = 1'b0; repeat (20) @(negedge clk);
    wr(8'hC8, 8'h02); wr(8'hC9, 8'h00);

    // R9: baud mode, with capture bit also set to test priority
    set16(8'hCA, 16'h00F0); set16(8'hCC, 16'hFFFE);
    t0 = n_baud;
    wr(8'hC8, 8'h27); pulse_t2(2);
    rd16(8'hCC, v); chk("R9 baud reload", v, 16'h00F0);
    chk("R9 one baud tick", n_baud - t0, 1);
    rd(8'hC8, b); chk("R9 no overflow flag", b, 8'h27);
    wr(8'hC8, 8'h02);

    // R10: clock-out toggles per reload
    cyc_fast = 1'b1;
    wr(8'hC9, 8'h02);
    set16(8'hCA, 16'hFFFC); set16(8'hCC, 16'hFFFC);
    wr(8'hC8, 8'h04);
    repeat (50) @(negedge clk);
    t0 = n_tog; repeat (6 * 40) @(negedge clk);
    chk("R10 ten toggles", n_tog - t0, 10);
    wr(8'hC8, 8'h06);
    set16(8'hCC, 16'hFFFF);
    t0 = n_tog; pulse_t2(2);
    chk("R10 no toggle in pin mode", n_tog - t0, 0);
    wr(8'hC8, 8'h00);

    summary();
  end
endmodule